// File: doc/BRIEF.md
# Weighted Round-Robin Cell Multiplexer

This block gathers fixed-length cells from eight serial-link receivers and merges them into one stream on a 16-bit parallel bus, so the bus master sees a single PHY. Each link writes its payload words into a shallow FIFO of its own. A weighted round-robin arbiter decides which link sends its next whole cell. Before the payload, the block inserts a one-word tag carrying the link number and a configured device number. This lets the ATM layer tell where each cell came from, in addition to the PHY ID that already sits inside the payload.

The bus side behaves as a slave. A cell-available flag tells the master that a complete cell is waiting. Each cycle the master holds the read strobe high, one word moves out, and it appears registered on the next cycle together with a valid flag. A start-of-cell flag marks the tag word. Toward the far end of every link, the block raises a back-pressure flag with hysteresis, so the sender pauses before the FIFO can overflow.

Top module: `wrr_cell_mux`

## Requirements
- R1: After reset, `bus_clav`, `bus_vld`, `bus_soc` and every bit of `lnk_bp` are low.
- R2: A cell on the bus is `CELL_WORDS+1` words long: the tag first, then the payload words in the order the link wrote them. A word appears on `bus_data` with `bus_vld` high in the cycle after the cycle in which `bus_rd` was sampled high.
- R3: The tag word holds the link number in bits [2:0] and `cfg_dev_id` in bits [7:3], and has zeros in bits [15:8]. `bus_soc` is high on the tag word and low on every payload word.
- R4: Links are served in round-robin order 0,1,…,7. A link keeps the grant for up to its weight (4-bit field `cfg_weights[4*i+3:4*i]`; a weight of 0 counts as 1) of consecutive cells, provided it still holds a complete cell. After that, the grant passes to the next link in order that holds one. After reset, the first link considered is link 0.
- R5: The grant changes only between cells. If `bus_rd` is low in the middle of a cell, the block emits nothing and later resumes with the next word of the same cell.
- R6: `bus_clav` is high exactly when some link FIFO holds a complete cell. A read strobe while no cell is available and none is in progress produces no valid word.
- R7: `lnk_bp[i]` goes high when link i's FIFO has room for fewer than two cells. It goes low only once the FIFO has room for four or more cells. Between those levels it keeps its previous value.
- R8: A word written to a link whose FIFO is full is dropped and does not change the stored contents.
- R9: Writing a link's FIFO in the same cycle that the bus drains it keeps every word, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_dev_id | input | 5 | Device number placed in the tag |
| cfg_weights | input | 4*NUM_LINKS | Per-link weight, 4 bits per link, link 0 in the low bits |
| lnk_wr | input | NUM_LINKS | Per-link write strobe, one payload word per cycle |
| lnk_wdata | input | 16*NUM_LINKS | Per-link write data, link 0 in the low bits |
| lnk_bp | output | NUM_LINKS | Per-link back-pressure toward the far end |
| bus_rd | input | 1 | Read strobe from the bus master |
| bus_clav | output | 1 | A complete cell is waiting |
| bus_data | output | 16 | Output word |
| bus_soc | output | 1 | Start of cell, high on the tag word |
| bus_vld | output | 1 | `bus_data` carries a word this cycle |

## Verification
Two things can happen to one link's FIFO in the same cycle: it is written from the link side and popped by the bus side. The bench provokes this by loading one cell into a link and then forking a second cell's writes against the bus reading the first. It judges the outcome by the exact payload order of both cells and by the cell-available flag dropping afterwards. A related overlap is a back-pressure threshold crossed by a pop rather than a push. The bench checks this on the hysteresis band while it drains a full FIFO cell by cell.

// File: rtl/wrr_mux_pkg.sv
package wrr_mux_pkg;
    localparam int TAG_LINK_W = 3;
    localparam int TAG_DEV_W  = 5;
    localparam int WEIGHT_W   = 4;
endpackage

// File: rtl/wrr_cell_fifo.sv
module wrr_cell_fifo #(
    parameter int DW         = 16,
    parameter int CELL_WORDS = 4,
    parameter int NCELLS     = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic          rd,
    output logic [DW-1:0] rdata,
    output logic          cell_rdy,
    output logic          bp
);
    localparam int DEPTH = NCELLS * CELL_WORDS;
    localparam int AW    = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int BP_ON_FREE  = 2 * CELL_WORDS;
    localparam int BP_OFF_FREE = 4 * CELL_WORDS;

    typedef struct packed {
        logic [AW-1:0]    wp;
        logic [AW-1:0]    rp;
        logic [CNT_W-1:0] cnt;
        logic             bp;
    } fst_t;

    fst_t q, d;
    logic [DW-1:0] mem [DEPTH];
    logic wr_ok, rd_ok;
    int   free_d;

    always_comb begin
        d      = q;
        wr_ok  = wr && (int'(q.cnt) != DEPTH);
        rd_ok  = rd && (q.cnt != '0);
        if (wr_ok) d.wp = (int'(q.wp) == DEPTH - 1) ? '0 : q.wp + 1'b1;
        if (rd_ok) d.rp = (int'(q.rp) == DEPTH - 1) ? '0 : q.rp + 1'b1;
        d.cnt  = q.cnt + CNT_W'(wr_ok) - CNT_W'(rd_ok);
        free_d = DEPTH - int'(d.cnt);
        if (free_d < BP_ON_FREE)       d.bp = 1'b1;
        else if (free_d >= BP_OFF_FREE) d.bp = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (wr_ok) mem[q.wp] <= wdata;
    end

    assign rdata    = mem[q.rp];
    assign cell_rdy = int'(q.cnt) >= CELL_WORDS;
    assign bp       = q.bp;

    AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        rd |-> (q.cnt != '0)); // R2
    AST_FULL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(q.cnt) == DEPTH && wr && !rd) |=> (int'(q.cnt) == DEPTH && $stable(q.wp))); // R8
    AST_BP_HIGH_NEAR_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (DEPTH - int'(q.cnt) < BP_ON_FREE) |-> bp); // R7
    AST_BP_LOW_ROOMY: assert property (@(posedge clk) disable iff (!rst_n)
        (DEPTH - int'(q.cnt) >= BP_OFF_FREE) |-> !bp); // R7
endmodule

// File: rtl/wrr_pick.sv
module wrr_pick
    import wrr_mux_pkg::*;
#(
    parameter int N      = 8,
    parameter int LINK_W = 3
) (
    input  logic [N-1:0]          elig,
    input  logic [N*WEIGHT_W-1:0] weights,
    input  logic [LINK_W-1:0]     ptr,
    input  logic [WEIGHT_W-1:0]   sent,
    output logic [LINK_W-1:0]     grant,
    output logic [WEIGHT_W-1:0]   sent_next,
    output logic                  any
);
    logic [WEIGHT_W-1:0] w_cur;
    logic                found;
    int                  idx;

    always_comb begin
        w_cur = weights[int'(ptr)*WEIGHT_W +: WEIGHT_W];
        if (w_cur == '0) w_cur = WEIGHT_W'(1);
        any       = |elig;
        grant     = ptr;
        sent_next = WEIGHT_W'(1);
        found     = 1'b0;
        idx       = 0;
        if (elig[ptr] && (sent < w_cur)) begin
            sent_next = sent + 1'b1;
        end else begin
            for (int k = 1; k <= N; k++) begin
                idx = (int'(ptr) + k) % N;
                if (!found && elig[idx]) begin
                    found = 1'b1;
                    grant = LINK_W'(idx);
                end
            end
        end
    end
endmodule

// File: rtl/wrr_cell_mux.sv
module wrr_cell_mux
    import wrr_mux_pkg::*;
#(
    parameter int NUM_LINKS  = 8,
    parameter int DW         = 16,
    parameter int CELL_WORDS = 4,
    parameter int NCELLS     = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [TAG_DEV_W-1:0]            cfg_dev_id,
    input  logic [NUM_LINKS*WEIGHT_W-1:0]   cfg_weights,
    input  logic [NUM_LINKS-1:0]            lnk_wr,
    input  logic [NUM_LINKS*DW-1:0]         lnk_wdata,
    output logic [NUM_LINKS-1:0]            lnk_bp,
    input  logic                            bus_rd,
    output logic                            bus_clav,
    output logic [DW-1:0]                   bus_data,
    output logic                            bus_soc,
    output logic                            bus_vld
);
    localparam int LINK_W = $clog2(NUM_LINKS);
    localparam int WC_W   = $clog2(CELL_WORDS + 1);

    typedef struct packed {
        logic                active;
        logic [WC_W-1:0]     wcnt;
        logic [LINK_W-1:0]   link;
        logic [LINK_W-1:0]   ptr;
        logic [WEIGHT_W-1:0] sent;
        logic [DW-1:0]       data;
        logic                soc;
        logic                vld;
    } st_t;

    st_t q, d;
    logic [NUM_LINKS-1:0] elig, pop;
    logic [DW-1:0]        f_rdata [NUM_LINKS];
    logic [LINK_W-1:0]    grant;
    logic [WEIGHT_W-1:0]  sent_next;
    logic                 any_elig;

    for (genvar i = 0; i < NUM_LINKS; i++) begin : g_link
        wrr_cell_fifo #(.DW(DW), .CELL_WORDS(CELL_WORDS), .NCELLS(NCELLS)) u_fifo (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr      (lnk_wr[i]),
            .wdata   (lnk_wdata[i*DW +: DW]),
            .rd      (pop[i]),
            .rdata   (f_rdata[i]),
            .cell_rdy(elig[i]),
            .bp      (lnk_bp[i])
        );
    end

    wrr_pick #(.N(NUM_LINKS), .LINK_W(LINK_W)) u_pick (
        .elig     (elig),
        .weights  (cfg_weights),
        .ptr      (q.ptr),
        .sent     (q.sent),
        .grant    (grant),
        .sent_next(sent_next),
        .any      (any_elig)
    );

    always_comb begin
        d     = q;
        d.vld = 1'b0;
        d.soc = 1'b0;
        pop   = '0;
        if (bus_rd && q.active) begin
            pop[q.link] = 1'b1;
            d.data      = f_rdata[q.link];
            d.vld       = 1'b1;
            if (int'(q.wcnt) == CELL_WORDS - 1) begin
                d.active = 1'b0;
                d.wcnt   = '0;
            end else begin
                d.wcnt = q.wcnt + 1'b1;
            end
        end else if (bus_rd && any_elig) begin
            d.data = '0;
            d.data[TAG_LINK_W-1:0] = TAG_LINK_W'(grant);
            d.data[TAG_LINK_W +: TAG_DEV_W] = cfg_dev_id;
            d.soc    = 1'b1;
            d.vld    = 1'b1;
            d.active = 1'b1;
            d.wcnt   = '0;
            d.link   = grant;
            d.ptr    = grant;
            d.sent   = sent_next;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.ptr  <= LINK_W'(NUM_LINKS - 1);
            q.sent <= '1;
        end else begin
            q <= d;
        end
    end

    assign bus_clav = |elig;
    assign bus_data = q.data;
    assign bus_soc  = q.soc;
    assign bus_vld  = q.vld;

    AST_SOC_NEEDS_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_soc |-> bus_vld); // R3
    AST_VLD_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_vld |-> $past(bus_rd)); // R2
    AST_SINGLE_POP: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pop)); // R5
    AST_MIDCELL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (q.active && !bus_rd) |=> (!bus_vld && $stable(q.link) && $stable(q.wcnt))); // R5
    AST_IDLE_READ_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !q.active && !bus_clav) |=> !bus_vld); // R6
    AST_START_ON_CLAV: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !q.active && bus_clav) |=> bus_soc); // R6
endmodule

// File: tb/wrr_cell_mux_tb.sv
module wrr_cell_mux_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N   = 8;
    localparam int DW  = 16;
    localparam int CW  = 4;
    localparam int NC  = 8;
    localparam logic [4:0] DEV = 5'h15;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [4:0]      cfg_dev_id = DEV;
    logic [N*4-1:0]  cfg_weights = '0;
    logic [N-1:0]    lnk_wr = '0;
    logic [N*DW-1:0] lnk_wdata = '0;
    logic [N-1:0]    lnk_bp;
    logic            bus_rd = 1'b0;
    logic            bus_clav;
    logic [DW-1:0]   bus_data;
    logic            bus_soc;
    logic            bus_vld;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wrr_cell_mux #(.NUM_LINKS(N), .DW(DW), .CELL_WORDS(CW), .NCELLS(NC)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_dev_id(cfg_dev_id), .cfg_weights(cfg_weights),
        .lnk_wr(lnk_wr), .lnk_wdata(lnk_wdata), .lnk_bp(lnk_bp), .bus_rd(bus_rd),
        .bus_clav(bus_clav), .bus_data(bus_data), .bus_soc(bus_soc), .bus_vld(bus_vld)
    );

    function automatic logic [15:0] pay(int l, int s, int i);
        return {4'(l), 8'(s), 4'(i)};
    endfunction

    function automatic logic [15:0] tag(int l);
        return {8'h00, DEV, 3'(l)};
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic write_cell(int l, int s);
        for (int i = 0; i < CW; i++) begin
            @(negedge clk);
            lnk_wr[l] = 1'b1;
            lnk_wdata[l*DW +: DW] = pay(l, s, i);
        end
        @(negedge clk);
        lnk_wr[l] = 1'b0;
    endtask

    // reads one cell; pause_at >= 1 inserts two idle strobes after that word
    task automatic read_cell(int l, int s, int pause_at, string req);
        @(negedge clk);
        bus_rd = 1'b1;
        for (int i = 0; i <= CW; i++) begin
            @(negedge clk);
            chk(bus_vld == 1'b1, req, 32'(bus_vld), 1);
            if (i == 0) begin
                chk(bus_data == tag(l), {req, "/R3 tag"}, 32'(bus_data), 32'(tag(l)));
                chk(bus_soc == 1'b1, "R3 soc on tag", 32'(bus_soc), 1);
            end else begin
                chk(bus_data == pay(l, s, i-1), {req, "/R2 payload"}, 32'(bus_data), 32'(pay(l, s, i-1)));
                chk(bus_soc == 1'b0, "R3 soc on payload", 32'(bus_soc), 0);
            end
            if (i == CW) begin
                bus_rd = 1'b0;
            end else if (i == pause_at) begin
                bus_rd = 1'b0;
                @(negedge clk);
                chk(bus_vld == 1'b0, "R5 pause no word", 32'(bus_vld), 0);
                @(negedge clk);
                chk(bus_vld == 1'b0, "R5 pause no word", 32'(bus_vld), 0);
                bus_rd = 1'b1;
            end
        end
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(bus_clav == 1'b0, "R1 clav", 32'(bus_clav), 0);
        chk(bus_vld == 1'b0, "R1 vld", 32'(bus_vld), 0);
        chk(bus_soc == 1'b0, "R1 soc", 32'(bus_soc), 0);
        chk(lnk_bp == '0, "R1 bp", 32'(lnk_bp), 0);
    endtask

    task automatic t_single_with_pause();
        write_cell(3, 0);
        chk(bus_clav == 1'b1, "R6 clav with cell", 32'(bus_clav), 1);
        read_cell(3, 0, 2, "R2/R5");
        @(negedge clk);
        chk(bus_clav == 1'b0, "R6 clav after drain", 32'(bus_clav), 0);
    endtask

    task automatic t_weighted();
        int order [12] = '{0, 0, 1, 2, 2, 2, 0, 0, 1, 2, 1, 1};
        int seq [N];
        cfg_weights = '0;
        cfg_weights[0*4 +: 4] = 4'd2;
        cfg_weights[1*4 +: 4] = 4'd0;   // counts as 1
        cfg_weights[2*4 +: 4] = 4'd3;
        for (int i = 3; i < N; i++) cfg_weights[i*4 +: 4] = 4'd1;
        for (int l = 0; l < 3; l++)
            for (int s = 0; s < 4; s++) write_cell(l, s);
        for (int l = 0; l < N; l++) seq[l] = 0;
        for (int c = 0; c < 12; c++) begin
            read_cell(order[c], seq[order[c]], -1, "R4 order");
            seq[order[c]]++;
        end
    endtask

    task automatic t_backpressure();
        for (int s = 0; s < 6; s++) write_cell(5, s);
        chk(lnk_bp[5] == 1'b0, "R7 room for two", 32'(lnk_bp[5]), 0);
        write_cell(5, 6);
        chk(lnk_bp[5] == 1'b1, "R7 room for one", 32'(lnk_bp[5]), 1);
        write_cell(5, 7);
        write_cell(5, 8);   // FIFO full: dropped
        chk(lnk_bp[5] == 1'b1, "R7 full", 32'(lnk_bp[5]), 1);
        for (int s = 0; s < 8; s++) begin
            read_cell(5, s, -1, "R8 contents");
            @(negedge clk);
            if (s < 3) chk(lnk_bp[5] == 1'b1, "R7 hysteresis hold", 32'(lnk_bp[5]), 1);
            if (s == 3) chk(lnk_bp[5] == 1'b0, "R7 clear at four", 32'(lnk_bp[5]), 0);
        end
        chk(bus_clav == 1'b0, "R8 dropped cell absent", 32'(bus_clav), 0);
    endtask

    task automatic t_idle_read();
        @(negedge clk);
        bus_rd = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(bus_vld == 1'b0, "R6 idle read", 32'(bus_vld), 0);
        end
        bus_rd = 1'b0;
    endtask

    task automatic t_concurrent();
        write_cell(6, 0);
        fork
            write_cell(6, 1);
            read_cell(6, 0, -1, "R9 first");
        join
        read_cell(6, 1, -1, "R9 second");
        @(negedge clk);
        chk(bus_clav == 1'b0, "R9 drained", 32'(bus_clav), 0);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_single_with_pause();
                t_weighted();
                t_backpressure();
                t_idle_read();
                t_concurrent();
            end
            begin
                #(CLK_PERIOD * 100000);
                errors++;
                checks++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule